// File: doc/BRIEF.md
# Boot Stream Block Loader

This engine loads a boot image into on-chip memory after reset without any processor involvement. A pulse on `start` makes it read the image from an external source port, starting at a fixed source address. The image is a chain of blocks, each made of a ten-byte header and, for most block types, a payload. The header gives a destination address, a byte count and a flags halfword. The engine handles each block according to its flags. It can fill a destination range with zero words. It can copy the payload into a 32-bit destination write port. It can copy the payload and then report a jump target to the core.

A jump request halts the engine. This lets the code just loaded run, for example to set up external memory, before later stages of the image are needed. A `resume` pulse then makes the engine carry on with the header that directly follows the init block. A block marked as final ends the run with `done` asserted.

Top module: `boot_block_loader`

## Requirements
- R1: A header is ten source bytes, read little-endian: bytes 0-3 are the destination address, bytes 4-7 the byte count, and bytes 8-9 the flags. Flag bit 0 selects zero-fill, flag bit 1 selects init, and flag bit 15 marks the final block.
- R2: For a copy block, payload bytes are packed four to a 32-bit word, with the first byte in bits 7:0. The words are written from the destination address upward, and the address rises by 4 for each word.
- R3: When a copy block's count is not a multiple of 4, the last word holds the remaining bytes in its low lanes and zeros in the upper lanes.
- R4: A zero-fill block writes ceil(count/4) zero words from its destination address, in steps of 4. It reads no payload, so the next header follows its header directly in the source.
- R5: A block with a count of 0 makes no destination write, and parsing goes on with the next header.
- R6: Each source read accepted moves the source address on by SRC_BYTES (1 for a byte-wide source, 2 for a halfword source). Reads are contiguous across all the headers and payloads of a run.
- R7: An init block is copied like a copy block. After its last write, `jumpValid` rises with `jumpAddr` equal to the block's destination address. While `jumpValid` is high, `busy`, `srcRd` and `dstWr` stay low.
- R8: A one-cycle `resume` pulse during a jump drops `jumpValid`. Parsing then restarts at the source address right after the init block's payload.
- R9: After a block with flag bit 15 has been processed, `done` goes high and stays high until the next `start`. `busy`, `done` and `jumpValid` are never high together.
- R10: `srcRd` keeps its address until a cycle with `srcValid` high, which transfers the data. `dstWr` keeps its address and data until a cycle with `dstReady` high.
- R11: During and right after reset, `busy`, `done`, `jumpValid`, `srcRd` and `dstWr` are low.
- R12: A `start` pulse while idle or done begins a fresh run at source address START_ADDR (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run from START_ADDR |
| resume | input | 1 | Continue after a jump request |
| srcRd | output | 1 | Source read request |
| srcAddr | output | ADDR_W | Source byte address |
| srcData | input | 8*SRC_BYTES | Source read data, lowest address in the low byte |
| srcValid | input | 1 | Source data valid; the read completes in this cycle |
| dstWr | output | 1 | Destination write request |
| dstAddr | output | ADDR_W | Destination byte address |
| dstData | output | 32 | Destination write word |
| dstReady | input | 1 | Destination accepts the write in this cycle |
| busy | output | 1 | Engine is parsing or transferring |
| done | output | 1 | Final block processed |
| jumpValid | output | 1 | Jump request pending |
| jumpAddr | output | ADDR_W | Jump target |

## Verification
The state that is hardest to reach from the ports is the mid-image pause. To get there, the engine must reach an init block with a payload write still stalled by `dstReady`. It must then raise the jump, stay silent on both memory ports for many cycles, and pick up at the exact source byte after the payload. The image places the init block behind a zero-fill block and an empty block, so a wrong source pointer shows up as a header misparse. The bench holds `resume` back while it checks every port each clock. A cycle-level model in the bench tracks the expected source address and the queue of expected writes. That model runs the image once with random stalls on both handshakes and once with no stalls.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

  localparam int HDR_BYTES = 10;
  localparam int FLAG_ZERO = 0;
  localparam int FLAG_INIT = 1;
  localparam int FLAG_LAST = 15;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_PARSE, S_ZERO, S_COPY, S_WRITE, S_FINISH, S_JUMP, S_DONE
  } loadState_t;

  typedef struct packed {
    logic restart;   // reload source pointer to the start address
    logic hdrTake;   // accept header bytes from the source
    logic loadBlk;   // latch header fields into the block registers
    logic payTake;   // accept payload bytes into the word assembler
    logic zeroStep;  // one zero word accepted
    logic wordStep;  // one assembled word accepted
    logic zeroSel;   // drive zeros on the write data
  } dpCtrl_t;

endpackage

// File: rtl/bsl_datapath.sv
module bsl_datapath
  import bsl_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SRC_BYTES  = 1,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCtrl_t                ctl,
  input  logic [8*SRC_BYTES-1:0] srcData,
  output logic [ADDR_W-1:0]      srcPtr,
  output logic [ADDR_W-1:0]      dstPtr,
  output logic [31:0]            wrData,
  output logic [ADDR_W-1:0]      blkAddr,
  output logic                   hdrLast,
  output logic                   hdrCntZero,
  output logic                   hdrZeroFlag,
  output logic                   initFlag,
  output logic                   lastFlag,
  output logic                   payLast,
  output logic                   laneFullNext,
  output logic                   zeroLast
);

  localparam int HDR_W = 8 * HDR_BYTES;

  logic [HDR_W-1:0] hdrReg;
  logic [3:0]       hdrCnt;
  logic [31:0]      remain;
  logic [31:0]      word;
  logic [2:0]       lane;
  logic [2:0]       take;
  logic             zeroFlagR;

  wire [31:0] hdrAddrF  = hdrReg[31:0];
  wire [31:0] hdrCountF = hdrReg[63:32];
  wire [15:0] hdrFlagsF = hdrReg[79:64];

  assign take         = (remain < 32'(SRC_BYTES)) ? remain[2:0] : 3'(SRC_BYTES);
  assign hdrLast      = (int'(hdrCnt) + SRC_BYTES) >= HDR_BYTES;
  assign hdrCntZero   = (hdrCountF == '0);
  assign hdrZeroFlag  = hdrFlagsF[FLAG_ZERO];
  assign payLast      = remain <= 32'(SRC_BYTES);
  assign laneFullNext = (4'(lane) + 4'(take)) >= 4'd4;
  assign zeroLast     = remain <= 32'd4;
  assign wrData       = ctl.zeroSel ? 32'd0 : word;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrReg    <= '0;
      hdrCnt    <= '0;
      srcPtr    <= START_ADDR;
      dstPtr    <= '0;
      remain    <= '0;
      word      <= '0;
      lane      <= '0;
      blkAddr   <= '0;
      zeroFlagR <= 1'b0;
      initFlag  <= 1'b0;
      lastFlag  <= 1'b0;
    end else begin
      if (ctl.restart) begin
        srcPtr <= START_ADDR;
        hdrCnt <= '0;
      end
      if (ctl.hdrTake) begin
        for (int k = 0; k < SRC_BYTES; k++) begin
          if (int'(hdrCnt) + k < HDR_BYTES)
            hdrReg[(int'(hdrCnt) + k)*8 +: 8] <= srcData[k*8 +: 8];
        end
        hdrCnt <= hdrCnt + 4'(SRC_BYTES);
        srcPtr <= srcPtr + ADDR_W'(SRC_BYTES);
      end
      if (ctl.loadBlk) begin
        dstPtr    <= ADDR_W'(hdrAddrF);
        blkAddr   <= ADDR_W'(hdrAddrF);
        remain    <= hdrCountF;
        zeroFlagR <= hdrFlagsF[FLAG_ZERO];
        initFlag  <= hdrFlagsF[FLAG_INIT];
        lastFlag  <= hdrFlagsF[FLAG_LAST];
        hdrCnt    <= '0;
        word      <= '0;
        lane      <= '0;
      end
      if (ctl.payTake) begin
        for (int k = 0; k < SRC_BYTES; k++) begin
          if (32'(k) < remain)
            word[(int'(lane) + k)*8 +: 8] <= srcData[k*8 +: 8];
        end
        remain <= remain - 32'(take);
        lane   <= lane + take;
        srcPtr <= srcPtr + ADDR_W'(SRC_BYTES);
      end
      if (ctl.zeroStep) begin
        dstPtr <= dstPtr + ADDR_W'(4);
        remain <= zeroLast ? 32'd0 : remain - 32'd4;
      end
      if (ctl.wordStep) begin
        dstPtr <= dstPtr + ADDR_W'(4);
        word   <= '0;
        lane   <= '0;
      end
    end
  end

  // Zero-fill flag is kept for the checks below only.
  AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.hdrTake || ctl.payTake) |=> srcPtr == $past(srcPtr) + ADDR_W'(SRC_BYTES)); // R6
  AST_ZERO_NO_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.zeroStep && zeroFlagR) |-> !ctl.payTake); // R4
  AST_DST_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.zeroStep || ctl.wordStep) |=> dstPtr == $past(dstPtr) + ADDR_W'(4)); // R2

endmodule

// File: rtl/bsl_control.sv
module bsl_control
  import bsl_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    resume,
  input  logic    srcValid,
  input  logic    dstReady,
  input  logic    hdrLast,
  input  logic    hdrCntZero,
  input  logic    hdrZeroFlag,
  input  logic    initFlag,
  input  logic    lastFlag,
  input  logic    payLast,
  input  logic    laneFullNext,
  input  logic    zeroLast,
  output dpCtrl_t ctl,
  output logic    srcRd,
  output logic    dstWr,
  output logic    busy,
  output logic    done,
  output logic    jumpValid
);

  loadState_t state, nextState;

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      S_IDLE, S_DONE: begin
        if (start) begin
          ctl.restart = 1'b1;
          nextState   = S_HDR;
        end
      end
      S_HDR: begin
        if (srcValid) begin
          ctl.hdrTake = 1'b1;
          if (hdrLast) nextState = S_PARSE;
        end
      end
      S_PARSE: begin
        ctl.loadBlk = 1'b1;
        if (hdrCntZero)       nextState = S_FINISH;
        else if (hdrZeroFlag) nextState = S_ZERO;
        else                  nextState = S_COPY;
      end
      S_ZERO: begin
        ctl.zeroSel = 1'b1;
        if (dstReady) begin
          ctl.zeroStep = 1'b1;
          if (zeroLast) nextState = S_FINISH;
        end
      end
      S_COPY: begin
        if (srcValid) begin
          ctl.payTake = 1'b1;
          if (laneFullNext || payLast) nextState = S_WRITE;
        end
      end
      S_WRITE: begin
        if (dstReady) begin
          ctl.wordStep = 1'b1;
          nextState    = payLast_q ? S_FINISH : S_COPY;
        end
      end
      S_FINISH: begin
        if (initFlag)      nextState = S_JUMP;
        else if (lastFlag) nextState = S_DONE;
        else               nextState = S_HDR;
      end
      S_JUMP: begin
        if (resume) nextState = lastFlag ? S_DONE : S_HDR;
      end
      default: nextState = S_IDLE;
    endcase
  end

  // Remembers that the word being written holds the block's last bytes.
  logic payLast_q;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) payLast_q <= 1'b0;
    else if (ctl.payTake) payLast_q <= payLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign srcRd     = (state == S_HDR) || (state == S_COPY);
  assign dstWr     = (state == S_ZERO) || (state == S_WRITE);
  assign busy      = !(state inside {S_IDLE, S_DONE, S_JUMP});
  assign done      = (state == S_DONE);
  assign jumpValid = (state == S_JUMP);

  AST_START_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && start) |=> srcRd); // R12
  AST_PARSE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PARSE) |=> state != S_PARSE); // R1

endmodule

// File: rtl/boot_block_loader.sv
module boot_block_loader
  import bsl_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SRC_BYTES  = 1,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic                   resume,
  output logic                   srcRd,
  output logic [ADDR_W-1:0]      srcAddr,
  input  logic [8*SRC_BYTES-1:0] srcData,
  input  logic                   srcValid,
  output logic                   dstWr,
  output logic [ADDR_W-1:0]      dstAddr,
  output logic [31:0]            dstData,
  input  logic                   dstReady,
  output logic                   busy,
  output logic                   done,
  output logic                   jumpValid,
  output logic [ADDR_W-1:0]      jumpAddr
);

  dpCtrl_t ctl;
  logic hdrLast, hdrCntZero, hdrZeroFlag, initFlag, lastFlag;
  logic payLast, laneFullNext, zeroLast;

  bsl_datapath #(
    .ADDR_W(ADDR_W), .SRC_BYTES(SRC_BYTES), .START_ADDR(START_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .srcData(srcData),
    .srcPtr(srcAddr), .dstPtr(dstAddr), .wrData(dstData), .blkAddr(jumpAddr),
    .hdrLast(hdrLast), .hdrCntZero(hdrCntZero), .hdrZeroFlag(hdrZeroFlag),
    .initFlag(initFlag), .lastFlag(lastFlag), .payLast(payLast),
    .laneFullNext(laneFullNext), .zeroLast(zeroLast)
  );

  bsl_control u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .resume(resume),
    .srcValid(srcValid), .dstReady(dstReady),
    .hdrLast(hdrLast), .hdrCntZero(hdrCntZero), .hdrZeroFlag(hdrZeroFlag),
    .initFlag(initFlag), .lastFlag(lastFlag), .payLast(payLast),
    .laneFullNext(laneFullNext), .zeroLast(zeroLast),
    .ctl(ctl), .srcRd(srcRd), .dstWr(dstWr),
    .busy(busy), .done(done), .jumpValid(jumpValid)
  );

  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (srcRd && !srcValid) |=> srcRd && $stable(srcAddr)); // R10
  AST_DST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dstWr && !dstReady) |=> dstWr && $stable(dstAddr) && $stable(dstData)); // R10
  AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busy, done, jumpValid})); // R9
  AST_JUMP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    jumpValid |-> !srcRd && !dstWr); // R7
  AST_JUMP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (jumpValid && !resume) |=> jumpValid && $stable(jumpAddr)); // R7
  AST_RESUME_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (jumpValid && resume) |=> !jumpValid); // R8
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done); // R9

endmodule

// File: tb/boot_block_loader_tb.sv
module boot_block_loader_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, resume = 1'b0;
  logic srcRd, dstWr, busy, done, jumpValid;
  logic [31:0] srcAddr, dstAddr, dstData, jumpAddr;
  logic [7:0] srcData = '0;
  logic srcValid = 1'b0, dstReady = 1'b0;

  always #2 clk = ~clk;

  boot_block_loader u_dut (
    .clk(clk), .rstN(rstN), .start(start), .resume(resume),
    .srcRd(srcRd), .srcAddr(srcAddr), .srcData(srcData), .srcValid(srcValid),
    .dstWr(dstWr), .dstAddr(dstAddr), .dstData(dstData), .dstReady(dstReady),
    .busy(busy), .done(done), .jumpValid(jumpValid), .jumpAddr(jumpAddr)
  );

  int compared = 0, mismatched = 0, cycles = 0;
  logic [7:0] mem [0:255];
  int imgLen;
  int expSrc;
  bit fast;
  logic [31:0] addrQ[$], dataQ[$];
  string tagQ[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Appends one block to the image and predicts its destination writes.
  task automatic addBlock(input logic [31:0] addr, input logic [31:0] cnt,
                          input logic [15:0] flags, input logic [7:0] seed);
    logic [7:0] hb [10];
    logic [31:0] w;
    for (int i = 0; i < 4; i++) hb[i] = addr[i*8 +: 8];
    for (int i = 0; i < 4; i++) hb[4+i] = cnt[i*8 +: 8];
    hb[8] = flags[7:0];
    hb[9] = flags[15:8];
    for (int i = 0; i < 10; i++) mem[imgLen+i] = hb[i];
    imgLen += 10;
    if (flags[0]) begin
      for (int i = 0; i < (int'(cnt) + 3) / 4; i++) begin
        addrQ.push_back(addr + 32'(4*i)); dataQ.push_back(32'd0); tagQ.push_back("R4");
      end
    end else begin
      for (int i = 0; i < int'(cnt); i += 4) begin
        w = '0;
        for (int b = 0; b < 4; b++)
          if (i + b < int'(cnt)) w[b*8 +: 8] = seed + 8'(i + b);
        addrQ.push_back(addr + 32'(i)); dataQ.push_back(w);
        tagQ.push_back(flags[1] ? "R7" : (i + 4 > int'(cnt)) ? "R3" : "R2");
      end
      for (int i = 0; i < int'(cnt); i++) mem[imgLen+i] = seed + 8'(i);
      imgLen += int'(cnt);
    end
  endtask

  task automatic buildImage();
    imgLen = 0; addrQ.delete(); dataQ.delete(); tagQ.delete();
    for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
    addBlock(32'h0000_0100, 32'd6, 16'h0000, 8'h11);   // copy, padded tail
    addBlock(32'h0000_0200, 32'd9, 16'h0001, 8'h00);   // zero-fill
    addBlock(32'h0000_0300, 32'd0, 16'h0000, 8'h00);   // empty block
    addBlock(32'h0000_0400, 32'd4, 16'h0002, 8'hA0);   // init
    addBlock(32'h0000_0500, 32'd5, 16'h8000, 8'h51);   // final copy
  endtask

  // Input drivers, updated just after each rising edge.
  always @(posedge clk) begin
    #1;
    srcValid = srcRd && !srcValid && (fast || ($urandom % 3 == 0));
    srcData  = mem[srcAddr[7:0]];
    dstReady = fast ? 1'b1 : ($urandom % 2 == 1);
  end

  // Per-clock reference comparison, away from the active edge.
  always @(negedge clk) begin
    if (rstN) begin
      if (srcRd && srcValid) begin
        chk(srcAddr == 32'(expSrc), "R6 source address", srcAddr, expSrc);
        expSrc++;
      end
      if (dstWr && dstReady) begin
        if (addrQ.size() == 0) begin
          chk(1'b0, "R5 unexpected write", dstAddr, 0);
        end else begin
          chk(dstAddr == addrQ[0], {tagQ[0], " write address"}, dstAddr, addrQ[0]);
          chk(dstData == dataQ[0], {tagQ[0], " write data"}, dstData, dataQ[0]);
          void'(addrQ.pop_front()); void'(dataQ.pop_front()); void'(tagQ.pop_front());
        end
      end
      if (jumpValid)
        chk(!srcRd && !dstWr && !busy, "R7 quiet during jump",
            {srcRd, dstWr, busy}, 0);
      chk($countones({busy, done, jumpValid}) <= 1, "R9 exclusive status",
          {busy, done, jumpValid}, 0);
    end
  end

  task automatic pulse(ref logic s);
    @(posedge clk); #1; s = 1'b1;
    @(posedge clk); #1; s = 1'b0;
  endtask

  task automatic runImage(input bit isFast);
    fast = isFast;
    buildImage();
    expSrc = 0;
    pulse(start);
    do @(negedge clk); while (!jumpValid);
    chk(jumpAddr == 32'h400, "R7 jump address", jumpAddr, 32'h400);
    chk(addrQ.size() == 2, "R7 init copy before jump", addrQ.size(), 2);
    chk(expSrc == 50, "R4 zero-fill consumed no payload", expSrc, 50);
    repeat (12) @(negedge clk);
    chk(jumpValid && !busy, "R7 jump held", {jumpValid, busy}, 2);
    pulse(resume);
    @(negedge clk);
    chk(!jumpValid, "R8 resume clears jump", jumpValid, 0);
    do @(negedge clk); while (!done);
    chk(addrQ.size() == 0, "R9 all writes before done", addrQ.size(), 0);
    chk(expSrc == imgLen, "R8 parsing continued after init", expSrc, imgLen);
    repeat (6) @(negedge clk);
    chk(done && !busy, "R9 done held", {done, busy}, 2);
  endtask

  initial begin
    fast = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !jumpValid && !srcRd && !dstWr, "R11 reset state",
        {busy, done, jumpValid, srcRd, dstWr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !srcRd && !dstWr, "R11 idle after reset",
        {busy, done, srcRd, dstWr}, 0);
    runImage(1'b0);
    runImage(1'b1);  // R12: second start runs again from address 0
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 20000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule